// File: doc/BRIEF.md
# Lock-on-First-Write Watchdog Timer

This block is a watchdog timer controlled through one 32-bit register on a plain write strobe and data bus. After reset the first write to the register fixes the whole configuration: a 12-bit reload count, a prescale choice, a run enable and a 2-bit expiry action. That configuration cannot be changed again until reset. Every later write, whatever its data, only restarts the countdown from the stored reload count.

The timer advances on a tick taken from every second clock cycle. With the prescale choice set, it advances only once per 16384 such half-rate ticks. When the count runs out, the block raises either an interrupt line or a reset-request line, as the action field selects. The line stays high until the block is reset. Reading the register returns the locked fields and a lock flag.

Top module: `wdt_once_top`

## Requirements
- R1: After reset, `rd_data` reads 0 and both `irq` and `rst_req` are low.
- R2: The first write latches the fields, and `rd_data` shows them from the cycle after that write: reload count in bits 11:0, prescale in bit 12, run enable in bit 13, action in bits 15:14, the lock flag (1) in bit 16, and zeros in bits 31:17.
- R3: Once the lock flag is set, no write changes any field that `rd_data` shows.
- R4: With prescale clear and reload N (N ≥ 1), the expiry output rises exactly 2·N clock cycles after the write that started the count. It is low one cycle earlier.
- R5: With prescale set, each count step takes 2·16384 clock cycles, so reload N expires exactly 32768·max(N,1) cycles after the starting write.
- R6: A write of any data while the timer is running restarts the count. Expiry then falls 2·N·(prescale factor) cycles after that write, and not at the time the earlier start would have given.
- R7: Action value 2 raises `irq` on expiry and leaves `rst_req` low. Action values 0, 1 and 3 raise `rst_req` and leave `irq` low.
- R8: Once an expiry output is high, it stays high through any later writes until reset.
- R9: If the first write has the run enable clear, the timer never expires, and later writes with the enable bit set do not start it.
- R10: A reload count of 0 expires after a single count step: 2 cycles without prescale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value: locked fields and lock flag |
| irq | output | 1 | Expiry interrupt, high until reset |
| rst_req | output | 1 | Expiry reset request, high until reset |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a running count. Such a write changes nothing in the readback, and its only visible effect is that the expiry moves later. The stimulus starts a count and writes again partway through. It then checks that the output is still low at the cycle where the first count would have expired, and that it rises exactly at the cycle set by the restarting write. The prescaled path is covered by one full run of 32768 cycles with reload 0. That run checks both the divider and the zero-reload rule.

// File: rtl/wdt_once_pkg.sv
package wdt_once_pkg;
  localparam int RLD_W = 12;
  localparam logic [1:0] ACT_IRQ = 2'd2;

  typedef struct packed {
    logic [1:0]       act;
    logic             run_en;
    logic             slow;
    logic [RLD_W-1:0] reload;
  } wdt_cfg_t;

  function automatic wdt_cfg_t decode_cfg(input logic [31:0] d);
    wdt_cfg_t c;
    c.reload = d[RLD_W-1:0];
    c.slow   = d[12];
    c.run_en = d[13];
    c.act    = d[15:14];
    return c;
  endfunction

  function automatic logic [31:0] pack_readback(input wdt_cfg_t c, input logic locked);
    return {15'd0, locked, c.act, c.run_en, c.slow, c.reload};
  endfunction

  function automatic logic action_is_irq(input logic [1:0] act);
    return act == ACT_IRQ;
  endfunction

  // Returns {expire, next count}; a count of 0 or 1 runs out on this step.
  function automatic logic [RLD_W:0] step_count(input logic [RLD_W-1:0] c);
    if (c <= 1) return {1'b1, {RLD_W{1'b0}}};
    return {1'b0, c - 1'b1};
  endfunction
endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_once_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output wdt_cfg_t    cfg_q,
  output logic        locked_q,
  output logic        first_wr
);
  assign first_wr = wr_en && !locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (first_wr) begin
      cfg_q    <= decode_cfg(wr_data);
      locked_q <= 1'b1;
    end
  end

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q));
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRESC_DIV = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow,
  output logic tick
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESC_DIV - 1);

  logic          half_q;
  logic [PW-1:0] pcnt_q;
  logic          pwrap;

  assign pwrap = (pcnt_q == PLAST);
  assign tick  = half_q && (!slow || pwrap);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      half_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      half_q <= !half_q;
      if (half_q && slow) pcnt_q <= pwrap ? '0 : pcnt_q + 1'b1;
    end
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_once_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             tick,
  input  logic [RLD_W-1:0] reload,
  output logic             expired_q
);
  logic [RLD_W-1:0] cnt_q;
  logic [RLD_W:0]   nxt;

  assign nxt = step_count(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      if (load) cnt_q <= reload;
      else if (run && tick) begin
        cnt_q     <= nxt[RLD_W-1:0];
        expired_q <= nxt[RLD_W];
      end
    end
  end

  assert_expiry_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |=> expired_q);
  assert_restart_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !expired_q) |=> (cnt_q == $past(reload)) && !expired_q);
  assert_idle_never_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !expired_q) |=> !expired_q);
endmodule

// File: rtl/wdt_once_top.sv
module wdt_once_top
  import wdt_once_pkg::*;
#(
  parameter int PRESC_DIV = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        rst_req
);
  wdt_cfg_t cfg_q;
  logic     locked_q, first_wr, run, load, tick, expired_q;
  logic     start_now;

  wdt_cfg_lock u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .locked_q(locked_q), .first_wr(first_wr)
  );

  // A start comes from the first write with enable, or any later write once running.
  assign run       = locked_q && cfg_q.run_en;
  assign start_now = first_wr ? wr_data[13] : run;
  assign load      = wr_en && start_now;

  wdt_tick_gen #(.PRESC_DIV(PRESC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(load),
    .slow(first_wr ? wr_data[12] : cfg_q.slow), .tick(tick)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .tick(tick),
    .reload(first_wr ? wr_data[RLD_W-1:0] : cfg_q.reload),
    .expired_q(expired_q)
  );

  assign rd_data = pack_readback(cfg_q, locked_q);
  assign irq     = expired_q && action_is_irq(cfg_q.act);
  assign rst_req = expired_q && !action_is_irq(cfg_q.act);

  assert_one_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && rst_req));
  assert_irq_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[15:14] == 2'd2));
  assert_locked_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[16]) |=> rd_data[16]);
endmodule

// File: tb/wdt_once_top_test.sv
module wdt_once_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;

  wdt_once_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  always #4 clk = !clk;

  typedef struct {
    int          at;
    logic        e_irq;
    logic        e_rst;
    logic [31:0] e_rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_errs = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares outputs at the negedge of the expected cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (e.at != cyc || irq !== e.e_irq || rst_req !== e.e_rst || rd_data !== e.e_rd) begin
        n_errs++;
        $display("FAIL %s at cyc %0d (want %0d): irq=%b rst_req=%b rd=%h expected irq=%b rst_req=%b rd=%h",
                 e.tag, cyc, e.at, irq, rst_req, rd_data, e.e_irq, e.e_rst, e.e_rd);
      end
    end
  end

  task automatic expect_at(input int at, input logic ei, input logic er,
                           input logic [31:0] rd, input string tag);
    exp_t e;
    e.at = at; e.e_irq = ei; e.e_rst = er; e.e_rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // Returns the clock edge that sampled the write.
  task automatic do_write(input logic [31:0] d, output int edge_n);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    edge_n = cyc; wr_en = 1'b0; wr_data = '0;
  endtask

  // Restated expiry latency: two clocks per half-rate tick, times prescale, times max(N,1).
  function automatic int latency(input logic [11:0] n, input bit slow);
    int steps = (n == 0) ? 1 : int'(n);
    return 2 * steps * (slow ? 16384 : 1);
  endfunction

  initial begin
    int e, e2, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_at(cyc + 1, 0, 0, 32'h0, "R1 reset state");

    // Action 0, enable, reload 5.
    do_reset();
    do_write(32'h0000_2005, e);
    t = latency(12'd5, 0);
    expect_at(e, 0, 0, 32'h0001_2005, "R2 readback after first write");
    expect_at(e + t - 1, 0, 0, 32'h0001_2005, "R4 low one cycle before expiry");
    expect_at(e + t, 0, 1, 32'h0001_2005, "R4 R7 rst_req at expiry, action 0");
    drain();
    do_write(32'hFFFF_FFFF, e2);
    expect_at(e2 + 1, 0, 1, 32'h0001_2005, "R3 fields unchanged by later write");
    expect_at(e2 + 40, 0, 1, 32'h0001_2005, "R8 expiry held after write");

    // Action 2, reload 10, restart midway.
    do_reset();
    do_write(32'h0000_A00A, e);
    expect_at(e, 0, 0, 32'h0001_A00A, "R2 readback action 2");
    repeat (7) @(negedge clk);
    do_write(32'h0000_0000, e2);
    t = latency(12'd10, 0);
    expect_at(e + t, 0, 0, 32'h0001_A00A, "R6 no expiry at original time");
    expect_at(e2 + t - 1, 0, 0, 32'h0001_A00A, "R6 low just before restarted expiry");
    expect_at(e2 + t, 1, 0, 32'h0001_A00A, "R6 R7 irq at restarted expiry");
    expect_at(e2 + t + 5, 1, 0, 32'h0001_A00A, "R8 irq held");

    // Action 1, prescaled, reload 0.
    do_reset();
    do_write(32'h0000_7000, e);
    t = latency(12'd0, 1);
    expect_at(e + t - 1, 0, 0, 32'h0001_7000, "R5 low one cycle before prescaled expiry");
    expect_at(e + t, 0, 1, 32'h0001_7000, "R5 R10 R7 prescaled expiry, action 1");

    // Disabled first write.
    do_reset();
    do_write(32'h0000_0001, e);
    expect_at(e, 0, 0, 32'h0001_0001, "R9 locked while disabled");
    drain();
    do_write(32'h0000_2003, e2);
    expect_at(e2 + 1, 0, 0, 32'h0001_0001, "R9 R3 enable not taken later");
    expect_at(e2 + 100, 0, 0, 32'h0001_0001, "R9 never expires");

    // Action 3, reload 0, no prescale.
    do_reset();
    do_write(32'h0000_E000, e);
    expect_at(e + 1, 0, 0, 32'h0001_E000, "R10 low after one cycle");
    expect_at(e + 2, 0, 1, 32'h0001_E000, "R10 R7 expiry after one step, action 3");
    drain();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_at(cyc + 1, 0, 0, 32'h0, "R8 R1 cleared only by reset");
    drain();
    done = 1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule